// File: doc/BRIEF.md
# Oversampling Manchester Line Decoder with Word Framer

This block recovers a Manchester-coded serial stream using a local clock that runs at nominally eight times the bit rate. The line is first brought into the local clock domain. The block then times the interval between line transitions to tell the mid-cell edges that carry data from the cell-boundary edges that do not. For each mid-cell edge it accepts, it emits a one-cycle bit strobe together with the recovered bit value.

A framer follows the bit recovery. It waits for a long run of zero bits and then a single one bit, which marks the start of a frame. It collects the next sixteen bits into a parallel word, placing the first bit received in the most significant position. It then loads the word into an output register and raises a one-cycle valid pulse. The output word holds its value until the next frame completes.

The block is intended for links where a remote sampler sends its readings over a cheap cable. The only shared reference between the two ends is the code itself.

Top module: `manchester_rx`

## Requirements
- R1: After reset, the bit strobe and the word-valid output are low and the word output is zero.
- R2: Each bit cell carries a transition at its middle. A one is low then high, a zero is high then low, and the line idles high. For every cell sent, the block raises exactly one single-cycle bit strobe, with the bit value equal to the line level in the second half of the cell.
- R3: A transition that arrives less than 3/4 of a nominal bit period (6 clocks at the default rate) after the last accepted mid-cell edge is a cell-boundary edge. It produces no strobe.
- R4: Bits are recovered correctly when the actual bit period is anywhere from 7 to 9 local clocks, so that each bit yields one strobe with the right value.
- R5: A one bit is taken as a frame start only if at least 18 zero bits were recovered since the end of the previous frame or since the last one bit. Exactly 18 zeros are enough.
- R6: A one bit preceded by only 17 zeros does not start a frame. No word-valid pulse follows, and the word output keeps its previous value.
- R7: After a start bit, the next 16 recovered bits form the word, with the first of them in bit 15. The word appears on the output together with a word-valid pulse one cycle long, and it stays unchanged until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, about 8x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Manchester-coded serial line, asynchronous |
| bit_stb_o | output | 1 | One-cycle strobe for each recovered bit |
| bit_val_o | output | 1 | Recovered bit value, valid with the strobe |
| word_o | output | 16 | Last completed parallel word |
| word_vld_o | output | 1 | One-cycle pulse when word_o is loaded |

## Verification
The bench targets three risks.

The first is the threshold between boundary and mid-cell edges. It runs long runs of identical bits, where boundary edges appear in every cell, and of alternating bits, where they do not. A decoder with the wrong threshold would either emit extra strobes or drop bits, and either error shifts every later frame.

The second is the lock rule. It sends a start bit after exactly 18 zeros, which must frame, and one after 17 zeros, which must be ignored. An off-by-one counter would either drop a valid frame or publish a spurious word.

The third is the clock mismatch. It sends bit periods of 7 and 9 clocks. A decoder that assumed an exact eight-clock cell would lose phase during all-ones and all-zeros words.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic {
        FR_HUNT = 1'b0,
        FR_RECV = 1'b1
    } fr_state_e;

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (STAGES > 1) begin
            s_d.chain = {s_q.chain[STAGES-2:0], d_i};
        end else begin
            s_d.chain = d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= {STAGES{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign q_o = s_q.chain[STAGES-1];

endmodule

// File: rtl/mdec_bitrec.sv
module mdec_bitrec #(
    parameter int OSR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic stb_o,
    output logic bit_o
);
    localparam int THR     = (OSR * 3) / 4;
    localparam int CNT_MAX = 2 * OSR - 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          stb;
        logic          bitv;
    } rec_t;

    rec_t r_d, r_q;
    logic edge_seen;
    logic late_edge;

    assign edge_seen = (line_s != r_q.prev);
    assign late_edge = (r_q.cnt >= CW'(THR));

    always_comb begin
        r_d      = r_q;
        r_d.prev = line_s;
        r_d.stb  = 1'b0;
        if (edge_seen && late_edge) begin
            r_d.cnt  = '0;
            r_d.stb  = 1'b1;
            r_d.bitv = line_s;
        end else if (r_q.cnt != CW'(CNT_MAX)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.prev <= 1'b1;
            r_q.cnt  <= CW'(CNT_MAX);
            r_q.stb  <= 1'b0;
            r_q.bitv <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stb_o = r_q.stb;
    assign bit_o = r_q.bitv;

    // R2: a strobe never lasts longer than one cycle
    a_r2_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stb |=> !r_q.stb);

    // R3: an edge too soon after the last accepted one yields no strobe
    a_r3_early_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !late_edge) |=> !r_q.stb);

endmodule

// File: rtl/mdec_framer.sv
module mdec_framer
    import mdec_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int LOCK_ZEROS = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o
);
    localparam int ZW = $clog2(LOCK_ZEROS + 1);
    localparam int BW = $clog2(WORD_W + 1);

    typedef struct packed {
        fr_state_e         state;
        logic [ZW-1:0]     zcnt;
        logic [BW-1:0]     bcnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] word;
        logic              vld;
    } fr_t;

    fr_t f_d, f_q;
    logic locked;

    assign locked = (f_q.zcnt == ZW'(LOCK_ZEROS));

    always_comb begin
        f_d     = f_q;
        f_d.vld = 1'b0;
        if (bit_stb) begin
            case (f_q.state)
                FR_HUNT: begin
                    if (!bit_val) begin
                        if (!locked) f_d.zcnt = f_q.zcnt + 1'b1;
                    end else if (locked) begin
                        f_d.state = FR_RECV;
                        f_d.bcnt  = '0;
                    end else begin
                        f_d.zcnt = '0;
                    end
                end
                FR_RECV: begin
                    f_d.shreg = {f_q.shreg[WORD_W-2:0], bit_val};
                    f_d.bcnt  = f_q.bcnt + 1'b1;
                    if (f_q.bcnt == BW'(WORD_W - 1)) begin
                        f_d.word  = {f_q.shreg[WORD_W-2:0], bit_val};
                        f_d.vld   = 1'b1;
                        f_d.state = FR_HUNT;
                        f_d.zcnt  = '0;
                    end
                end
                default: f_d.state = FR_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.state <= FR_HUNT;
            f_q.zcnt  <= '0;
            f_q.bcnt  <= '0;
            f_q.shreg <= '0;
            f_q.word  <= '0;
            f_q.vld   <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign word_o = f_q.word;
    assign vld_o  = f_q.vld;

    // R5: a one bit without enough preceding zeros never opens a frame
    a_r5_no_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == FR_HUNT && bit_stb && bit_val && !locked) |=> (f_q.state == FR_HUNT));

    // R7: the word only changes together with a valid pulse
    a_r7_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !f_q.vld |-> $stable(f_q.word));

endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
    parameter int OSR         = 8,
    parameter int WORD_W      = 16,
    parameter int LOCK_ZEROS  = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic              bit_stb_o,
    output logic              bit_val_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o
);
    logic line_s;
    logic stb;
    logic bitv;

    mdec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (line_s)
    );

    mdec_bitrec #(.OSR(OSR)) u_bitrec (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (line_s),
        .stb_o  (stb),
        .bit_o  (bitv)
    );

    mdec_framer #(.WORD_W(WORD_W), .LOCK_ZEROS(LOCK_ZEROS)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (stb),
        .bit_val (bitv),
        .word_o  (word_o),
        .vld_o   (word_vld_o)
    );

    assign bit_stb_o = stb;
    assign bit_val_o = bitv;

    // R7: word valid is a single-cycle pulse
    a_r7_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    // R7: a word completes only on the cycle after a bit strobe
    a_r7_vld_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_vld_o) |-> $past(bit_stb_o));

endmodule

// File: tb/manchester_rx_tb.sv
module manchester_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_i = 1'b1;
    logic        bit_stb_o;
    logic        bit_val_o;
    logic [15:0] word_o;
    logic        word_vld_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    logic        exp_bits[$];
    logic [15:0] exp_words[$];

    always #4 clk = ~clk;

    manchester_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_i),
        .bit_stb_o  (bit_stb_o),
        .bit_val_o  (bit_val_o),
        .word_o     (word_o),
        .word_vld_o (word_vld_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: R2/R3 bit scoreboard, R7 word scoreboard
    always @(negedge clk) begin
        if (rst_n && bit_stb_o) begin
            if (exp_bits.size() == 0) begin
                check(1'b0, "R3 extra strobe", 32'(bit_val_o), 32'hx);
            end else begin
                logic e;
                e = exp_bits.pop_front();
                check(bit_val_o == e, "R2 bit value", 32'(bit_val_o), 32'(e));
            end
        end
        if (rst_n && word_vld_o) begin
            if (exp_words.size() == 0) begin
                check(1'b0, "R6 unexpected word", 32'(word_o), 32'hx);
            end else begin
                logic [15:0] w;
                w = exp_words.pop_front();
                check(word_o == w, "R7 word value", 32'(word_o), 32'(w));
            end
        end
    end

    task automatic send_bit(input logic b, input int h1, input int h2);
        exp_bits.push_back(b);
        line_i = ~b;
        repeat (h1) @(posedge clk);
        #1 line_i = b;
        repeat (h2) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input int zeros, input logic [15:0] w, input bit expect_word,
                              input int h1, input int h2);
        for (int i = 0; i < zeros; i++) send_bit(1'b0, h1, h2);
        if (expect_word) exp_words.push_back(w);
        send_bit(1'b1, h1, h2);
        for (int i = 15; i >= 0; i--) send_bit(w[i], h1, h2);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        check(bit_stb_o == 1'b0, "R1 strobe at reset", 32'(bit_stb_o), 0);
        check(word_vld_o == 1'b0, "R1 valid at reset", 32'(word_vld_o), 0);
        check(word_o == 16'h0, "R1 word at reset", 32'(word_o), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(bit_stb_o == 1'b0, "R1 idle line no strobe", 32'(bit_stb_o), 0);

        // R2 R5 R7: mixed pattern, long preamble
        send_frame(20, 16'hA5C3, 1'b1, 4, 4);
        // R5: exactly the minimum zero run
        send_frame(18, 16'h0001, 1'b1, 4, 4);
        // R6: one zero short, start must be ignored
        send_frame(17, 16'h8181, 1'b0, 4, 4);
        check(word_o == 16'h0001, "R6 word kept", 32'(word_o), 32'h0001);
        // R4: short bit period, all ones
        send_frame(20, 16'hFFFF, 1'b1, 3, 4);
        // R4: long bit period, all zeros
        send_frame(20, 16'h0000, 1'b1, 4, 5);
        // R7: MSB-first placement
        send_frame(19, 16'h8000, 1'b1, 4, 4);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 4, 4);
        repeat (40) @(posedge clk);
        #1;
        // R3: every cell gave exactly one strobe
        check(exp_bits.size() == 0, "R3 missing strobes", 32'(exp_bits.size()), 0);
        check(exp_words.size() == 0, "R5 missing words", 32'(exp_words.size()), 0);
        check(word_o == 16'h8000, "R7 word holds", 32'(word_o), 32'h8000);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule